// File: doc/BRIEF.md
# Pipelined Ring Round-Robin Arbiter

This block decides which of N tiles may use one shared switch output. The tiles sit on a logical ring. A rotating priority pointer marks the start of the search. Each round picks the first eligible requester at or after the pointer, wrapping past the top of the ring. The search runs on a parallel OR-prefix tree built over a doubled request vector. The "already blocked" signal ripples upward through that tree in the way a carry ripples through a prefix adder. The tree is cut by one register, so a decision takes three cycles from request to grant. The pipeline accepts a fresh request vector on every cycle.

Each tile may hold at most two grants at the same time. A held grant is returned with a one-cycle release pulse on that tile's release line. The arbiter counts the grants each tile holds. A tile that already holds two is dropped from the search when its request enters the pipeline. Rounds already in flight can still carry a third grant for a tile. For that case there is a final check at issue time, which suppresses that grant. A round that produces a grant moves the pointer just past the winner. A round without a grant leaves the pointer where it is.

Top module: `rr_prefix_arb`

## Requirements
- R1: `gnt` has at most one bit set in any cycle, and `gnt_vld` is high exactly in the cycles where one bit of `gnt` is set. Bit i of `gnt` means tile i was granted.
- R2: A request vector present before clock edge t is answered by `gnt`/`gnt_vld` after edge t+2, a latency of three cycles. A new vector is accepted on every edge, and every granted tile had its `req` bit set three cycles earlier.
- R3: The winner of a round is the first candidate met when walking from the pointer index upward, wrapping from N-1 to 0. A candidate is a tile whose request bit was set and whose held count was below two when the vector entered. The pointer used is the one in place when the vector entered.
- R4: When a round issues a grant to tile w, the pointer becomes (w+1) mod N. A round without a grant leaves the pointer unchanged.
- R5: Each grant adds one to the tile's held count. Each `rel` pulse on a tile with a nonzero count removes one. A release therefore lets the tile be granted again.
- R6: A tile holding two grants is not a candidate. Its request neither wins nor blocks any other tile.
- R7: If the winner of a round already holds two grants at issue time, because earlier rounds in flight granted it, that round issues no grant and leaves the pointer unchanged.
- R8: A `rel` pulse on a tile whose held count is zero is ignored. The count does not wrap.
- R9: During and right after reset, `gnt` is zero, `gnt_vld` is low, the pointer is at tile 0, and all held counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N | Request bit per tile, sampled every cycle |
| rel | input | N | Release pulse per tile, returns one held grant |
| gnt | output | N | One-hot grant, one cycle per issued grant |
| gnt_vld | output | 1 | High in the cycle a grant is issued |

## Verification
The hardest situation to reach is the issue-time suppression. It needs several rounds for the same tile to be in flight while that tile's held count climbs to two. The count rises only from grants that come out of those same rounds. The bench reaches it by holding one tile's request for several consecutive cycles with no release, so that three rounds enter with a count of zero. It then checks that exactly two grants emerge. A release on an idle tile, followed by a burst of requests from that tile, shows whether the count wrapped below zero.

// File: rtl/rr_prefix_arb.sv
module rr_prefix_arb #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] rel,
  output logic [N-1:0] gnt,
  output logic         gnt_vld
);
  localparam int PW  = (N > 1) ? $clog2(N) : 1;
  localparam int W2  = 2 * N;
  localparam int LV  = $clog2(W2);
  localparam int MID = LV / 2;

  logic [PW-1:0] ptr;
  logic [1:0]    held [N];
  logic [N-1:0]  room;
  logic [N-1:0]  cand;
  logic [N-1:0]  lowm;
  logic [W2-1:0] s1_dv, s2_dv, s2_pre, first;
  logic [W2-1:0] pa [MID+1];
  logic [W2-1:0] pb [LV-MID+1];
  logic [N-1:0]  pick;
  logic [PW-1:0] win, nxt;
  logic          issue;

  // stage 1: eligibility and pointer split into a doubled vector
  assign cand = req & room;
  assign lowm = (N'(1) << ptr) - N'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s1_dv <= '0;
    else        s1_dv <= {cand, cand & ~lowm};

  // stage 2: lower prefix levels
  assign pa[0] = s1_dv;
  for (genvar l = 0; l < MID; l++) begin : g_lo
    assign pa[l+1] = pa[l] | (pa[l] << (2**l));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s2_dv  <= '0;
      s2_pre <= '0;
    end else begin
      s2_dv  <= s1_dv;
      s2_pre <= pa[MID];
    end

  // stage 3: upper prefix levels, first-set, fold, issue
  assign pb[0] = s2_pre;
  for (genvar l = MID; l < LV; l++) begin : g_hi
    assign pb[l-MID+1] = pb[l-MID] | (pb[l-MID] << (2**l));
  end

  assign first = s2_dv & ~(pb[LV-MID] << 1);
  assign pick  = first[N-1:0] | first[W2-1:N];

  always_comb begin
    win = '0;
    for (int i = 0; i < N; i++)
      if (pick[i]) win = PW'(i);
  end

  assign issue = (pick != '0) && (held[win] != 2'd2);
  assign nxt   = (win == PW'(N-1)) ? '0 : win + PW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gnt     <= '0;
      gnt_vld <= 1'b0;
      ptr     <= '0;
    end else begin
      gnt     <= issue ? pick : '0;
      gnt_vld <= issue;
      if (issue) ptr <= nxt;
    end

  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic up, dn;
    assign room[i] = (held[i] != 2'd2);
    assign up = issue && pick[i];
    assign dn = rel[i] && (held[i] != 2'd0);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          held[i] <= 2'd0;
      else if (up && !dn)  held[i] <= held[i] + 2'd1;
      else if (dn && !up)  held[i] <= held[i] - 2'd1;

    assert_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      held[i] != 2'd3);
    assert_no_third_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |-> $past(held[i]) != 2'd2);
  end

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> (($past(req, 3) & gnt) != '0));
  assert_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> gnt[(ptr == '0) ? PW'(N-1) : ptr - PW'(1)]);
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld |-> $stable(ptr));
endmodule

// File: tb/rr_prefix_arb_tb_top.sv
`timescale 1ns/1ps
module rr_prefix_arb_tb_top;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] rel = '0;
  logic [N-1:0] gnt;
  logic gnt_vld;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R9";
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rr_prefix_arb #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .rel(rel),
    .gnt(gnt), .gnt_vld(gnt_vld)
  );

  // behavioural reference model
  int m_held [N];
  int m_ptr, m_p1, m_p2, m_w, m_j;
  bit m_f;
  logic [N-1:0] m_s1, m_s2, m_c, m_gnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_held[i] = 0;
      m_ptr = 0; m_p1 = 0; m_p2 = 0;
      m_s1 = '0; m_s2 = '0; m_gnt = '0;
    end else begin
      m_f = 1'b0; m_w = 0;
      for (int k = 0; k < N; k++) begin
        m_j = (m_p2 + k) % N;
        if (!m_f && m_s2[m_j]) begin m_f = 1'b1; m_w = m_j; end
      end
      if (m_f && m_held[m_w] >= 2) m_f = 1'b0;
      for (int i = 0; i < N; i++) m_c[i] = req[i] && (m_held[i] < 2);
      m_s2 = m_s1; m_p2 = m_p1; m_s1 = m_c; m_p1 = m_ptr;
      for (int i = 0; i < N; i++)
        m_held[i] = m_held[i] + ((m_f && m_w == i) ? 1 : 0) - ((rel[i] && m_held[i] > 0) ? 1 : 0);
      m_gnt = m_f ? (N'(1) << m_w) : '0;
      if (m_f) m_ptr = (m_w + 1) % N;
    end
  end

  // observed winners
  int wq[$];
  int dcnt [N];
  always @(negedge clk) begin
    if (rst_n && gnt_vld)
      for (int i = 0; i < N; i++)
        if (gnt[i]) begin wq.push_back(i); dcnt[i]++; end
    if (rst_n && cmp_en) begin
      n_chk++;
      if (gnt !== m_gnt || gnt_vld !== (m_gnt != '0)) begin
        n_fail++;
        $display("FAIL %s cycle compare: actual gnt=%h vld=%b expected gnt=%h vld=%b",
                 tag, gnt, gnt_vld, m_gnt, (m_gnt != '0));
      end
    end
  end

  task automatic check(bit ok, string r, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_first(logic [N-1:0] v, int p);
    for (int k = 0; k < N; k++)
      if (v[(p + k) % N]) return (p + k) % N;
    return -1;
  endfunction

  task automatic pulse(logic [N-1:0] v);
    @(negedge clk); req = v;
    @(negedge clk); req = '0;
    cyc(5);
  endtask

  initial begin
    int p, e;
    logic [N-1:0] v;
    cyc(2);
    check(gnt == '0 && gnt_vld == 1'b0, "R9 reset outputs", int'(gnt_vld), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    cyc(1);
    check(gnt == '0, "R9 idle after reset", int'(gnt), 0);

    // first grant after reset starts at tile 0
    tag = "R9"; rel = '1;
    wq.delete();
    pulse('1);
    check(wq.size() == 1 && wq[0] == 0, "R9 pointer starts at 0", (wq.size() > 0) ? wq[0] : -1, 0);

    // latency
    tag = "R2";
    @(negedge clk); req = N'(1) << 7;
    @(negedge clk); req = '0;
    check(gnt == '0, "R2 no grant after 1 cycle", int'(gnt_vld), 0);
    @(negedge clk);
    check(gnt == '0, "R2 no grant after 2 cycles", int'(gnt_vld), 0);
    @(negedge clk);
    check(gnt_vld && gnt[7], "R2 grant after 3 cycles", int'(gnt), 1 << 7);
    cyc(4);

    // pointer advance
    tag = "R4";
    wq.delete();
    pulse('1); pulse('1); pulse('1);
    check(wq.size() == 3, "R4 three grants", wq.size(), 3);
    if (wq.size() == 3) begin
      check(wq[0] == 8, "R4 first after tile 7", wq[0], 8);
      check(wq[1] == (wq[0] + 1) % N, "R4 advance 1", wq[1], (wq[0] + 1) % N);
      check(wq[2] == (wq[0] + 2) % N, "R4 advance 2", wq[2], (wq[0] + 2) % N);
      p = (wq[2] + 1) % N;
    end else p = 0;

    // wrap below pointer
    tag = "R3";
    v = '0; v[(p + N - 1) % N] = 1'b1; v[(p + N - 3) % N] = 1'b1;
    e = exp_first(v, p);
    wq.delete();
    pulse(v);
    check(wq.size() == 1 && wq[0] == e, "R3 wrap search", (wq.size() > 0) ? wq[0] : -1, e);
    p = (e + 1) % N;
    v = '0; v[(p + 2) % N] = 1'b1; v[(p + N - 1) % N] = 1'b1;
    e = exp_first(v, p);
    wq.delete();
    pulse(v);
    check(wq.size() == 1 && wq[0] == e, "R3 above pointer first", (wq.size() > 0) ? wq[0] : -1, e);

    // hold cap and in-flight suppression
    tag = "R6"; rel = '0;
    cyc(2);
    dcnt[3] = 0;
    @(negedge clk); req = N'(1) << 3;
    cyc(6);
    req = '0;
    cyc(5);
    check(dcnt[3] == 2, "R7 in-flight third grant suppressed, R6 cap", dcnt[3], 2);
    tag = "R6";
    dcnt[4] = 0;
    pulse((N'(1) << 3) | (N'(1) << 4));
    check(dcnt[4] == 1, "R6 capped tile does not block", dcnt[4], 1);
    check(dcnt[3] == 2, "R6 capped tile ignored", dcnt[3], 2);

    tag = "R5";
    @(negedge clk); rel = N'(1) << 3;
    @(negedge clk); rel = '0;
    pulse(N'(1) << 3);
    check(dcnt[3] == 3, "R5 release frees a slot", dcnt[3], 3);

    // release at zero ignored
    tag = "R8";
    dcnt[5] = 0;
    @(negedge clk); rel = N'(1) << 5;
    cyc(2);
    rel = '0;
    @(negedge clk); req = N'(1) << 5;
    cyc(3);
    req = '0;
    cyc(5);
    check(dcnt[5] == 2, "R8 no wrap on empty release", dcnt[5], 2);

    // free everything, then mixed traffic
    tag = "R1";
    @(negedge clk); rel = '1;
    cyc(3);
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      req = N'($urandom) & ((c % 3 == 0) ? N'($urandom) : '1);
      rel = N'($urandom) & N'($urandom);
      tag = (c < 1500) ? "R3" : "R5";
    end
    @(negedge clk); req = '0; rel = '1;
    cyc(5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule